// File: doc/BRIEF.md
# Bus wake-up pattern detector

One channel of a standby-mode wake-up path for a two-wire differential bus. A low-power receiver delivers a single digitised bit per clock cycle, where 1 means the bus is dominant. The block synchronises that bit and removes short glitches from it. It then looks for a qualified dominant, recessive, dominant sequence. When a full sequence is found, it raises a sticky wake flag.

Until the flag is set, the receive output is held recessive. Once a wake-up has been recognised, the filtered bus level is passed to the receive output. The channel stays in standby during this time. The mode decision lives outside this block.

Four things abandon a partly received sequence: the channel leaving standby, an I/O-supply undervoltage, a phase that is too short, or an overall time limit. After any of these, the sequence has to start again from its first dominant phase. All durations are parameters counted in clock cycles.

Top module: `wkp_wake_detector`

## Requirements
- R1: After reset, `wake_o` is 0 and `rxd_o` is 1 (recessive).
- R2: The raw bus bit passes through `SYNC_STAGES` flops. The filtered level only takes the synchronised value once that value has differed from it for `FLT_CYC` consecutive cycles. Shorter dominant or recessive excursions leave the filtered level unchanged.
- R3: A valid wake-up has three filtered phases: a dominant phase of at least `DOM_CYC` cycles, then a recessive phase of at least `REC_CYC` cycles, then a dominant phase. `wake_o` rises on the clock edge that completes the `DOM_CYC`-th cycle of that last dominant phase. Counted from the first raw dominant sample P0, this is edge P0 + `SYNC_STAGES` + `FLT_CYC` + d1 + r + `DOM_CYC` - 1.
- R4: If the first dominant phase is shorter than `DOM_CYC`, or the recessive phase is shorter than `REC_CYC`, or the final dominant phase is shorter than `DOM_CYC`, no wake-up results. After a short first phase or a short recessive phase, the next dominant edge starts a new sequence. A short final dominant phase does not start one.
- R5: Timing is measured from the first filtered dominant cycle of a sequence. The sequence only counts if its final dominant phase reaches `DOM_CYC` cycles within `TO_CYC` filtered cycles, that is d1 + r + `DOM_CYC` <= `TO_CYC`. Otherwise the sequence is dropped when `TO_CYC` cycles have elapsed. A dominant edge that falls on that expiry cycle begins a new sequence.
- R6: A bus held dominant indefinitely never produces a wake-up.
- R7: While `stby_i` = 0 (normal mode), any partial sequence is discarded and `wake_o` is cleared on the next edge.
- R8: While `vio_uv_i` = 1, any partial sequence is discarded. An already-set `wake_o` is not cleared by undervoltage.
- R9: While `wake_o` = 0, `rxd_o` stays 1 whatever the bus does.
- R10: While `wake_o` = 1, `rxd_o` is the inverse of the filtered bus level (0 = dominant).
- R11: Once set, `wake_o` stays 1 for as long as `stby_i` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_dom_i | input | 1 | Raw bus bit from the low-power receiver, 1 = dominant |
| stby_i | input | 1 | 1 = channel in standby, 0 = normal mode |
| vio_uv_i | input | 1 | 1 = I/O supply below its undervoltage level |
| wake_o | output | 1 | Sticky wake-up flag |
| rxd_o | output | 1 | Gated filtered bus level, 0 = dominant, 1 = recessive |

## Verification
Some properties are checked by assertions on every cycle:
- the filtered level holds while the mismatch counter is short of its limit;
- leaving standby or undervoltage empties the sequencer;
- the flag clears in normal mode and stays set in standby;
- the elapsed-time counter never passes its limit;
- the flag only rises from the final dominant phase while the bus is dominant.

Other behaviour can only be shown by the bench's scenarios:
- the exact edge on which the flag rises;
- the timeout boundary at d1 + r + `DOM_CYC` = `TO_CYC`;
- restart on an edge coinciding with expiry;
- glitches inside the recessive gap;
- a clamped bus;
- the gating of the receive output.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DOM1 = 2'd1,
    ST_REC  = 2'd2,
    ST_DOM2 = 2'd3
  } wkp_state_e;

  function automatic int unsigned wkp_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wkp_glitch_filter.sv
module wkp_glitch_filter #(
  parameter int unsigned FLT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);

  localparam int unsigned CW = (FLT_CYC > 1) ? $clog2(FLT_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FLT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  // level moves only after FLT_CYC consecutive mismatching samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  AST_FLT_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == filt_q) |=> $stable(filt_q)); // R2
  AST_FLT_SHORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_i != filt_q) && (cnt_q != CNT_LAST)) |=> $stable(filt_q)); // R2

endmodule

// File: rtl/wkp_seq_fsm.sv
module wkp_seq_fsm
  import wkp_pkg::*;
#(
  parameter int unsigned DOM_CYC = 8,
  parameter int unsigned REC_CYC = 8,
  parameter int unsigned TO_CYC  = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_i,
  input  logic stby_i,
  input  logic uv_i,
  output logic wake_o
);

  localparam int unsigned PH_MAX = wkp_max(DOM_CYC, REC_CYC);
  localparam int unsigned PW     = $clog2(PH_MAX + 1);
  localparam int unsigned TW     = $clog2(TO_CYC + 1);
  localparam logic [PW-1:0] PH_SAT   = PW'(PH_MAX);
  localparam logic [PW-1:0] DOM_MIN  = PW'(DOM_CYC);
  localparam logic [PW-1:0] DOM_LAST = PW'(DOM_CYC - 1);
  localparam logic [PW-1:0] REC_MIN  = PW'(REC_CYC);
  localparam logic [TW-1:0] TO_LIM   = TW'(TO_CYC);

  wkp_state_e    state_q, state_d;
  logic [PW-1:0] pcnt_q, pcnt_d, pcnt_inc;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          wake_q, wake_d;
  logic          filt_prev_q;
  logic          abort, rise, tmo;

  assign abort    = !stby_i || uv_i;
  assign rise     = filt_i && !filt_prev_q;
  assign tmo      = (state_q != ST_IDLE) && (tcnt_q == TO_LIM);
  assign pcnt_inc = (pcnt_q == PH_SAT) ? pcnt_q : pcnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    tcnt_d  = (state_q != ST_IDLE) ? tcnt_q + 1'b1 : '0;
    wake_d  = wake_q;
    if (abort) begin
      state_d = ST_IDLE;
      pcnt_d  = '0;
      tcnt_d  = '0;
      if (!stby_i) wake_d = 1'b0;
    end else if (wake_q) begin
      state_d = ST_IDLE;
      pcnt_d  = '0;
      tcnt_d  = '0;
    end else if (tmo) begin
      // expiry; an edge on this very cycle opens a fresh sequence
      if (rise) begin
        state_d = ST_DOM1;
        pcnt_d  = PW'(1);
        tcnt_d  = TW'(1);
      end else begin
        state_d = ST_IDLE;
        pcnt_d  = '0;
        tcnt_d  = '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rise) begin
            state_d = ST_DOM1;
            pcnt_d  = PW'(1);
            tcnt_d  = TW'(1);
          end
        end
        ST_DOM1: begin
          if (filt_i) begin
            pcnt_d = pcnt_inc;
          end else if (pcnt_q >= DOM_MIN) begin
            state_d = ST_REC;
            pcnt_d  = PW'(1);
          end else begin
            state_d = ST_IDLE;
            pcnt_d  = '0;
            tcnt_d  = '0;
          end
        end
        ST_REC: begin
          if (!filt_i) begin
            pcnt_d = pcnt_inc;
          end else if (pcnt_q >= REC_MIN) begin
            state_d = ST_DOM2;
            pcnt_d  = PW'(1);
          end else begin
            // gap too short: this dominant edge starts over
            state_d = ST_DOM1;
            pcnt_d  = PW'(1);
            tcnt_d  = TW'(1);
          end
        end
        ST_DOM2: begin
          if (filt_i && (pcnt_q == DOM_LAST)) begin
            wake_d  = 1'b1;
            state_d = ST_IDLE;
            pcnt_d  = '0;
            tcnt_d  = '0;
          end else if (filt_i) begin
            pcnt_d = pcnt_inc;
          end else begin
            state_d = ST_IDLE;
            pcnt_d  = '0;
            tcnt_d  = '0;
          end
        end
        default: begin
          state_d = ST_IDLE;
          pcnt_d  = '0;
          tcnt_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pcnt_q      <= '0;
      tcnt_q      <= '0;
      wake_q      <= 1'b0;
      filt_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      pcnt_q      <= pcnt_d;
      tcnt_q      <= tcnt_d;
      wake_q      <= wake_d;
      filt_prev_q <= filt_i;
    end
  end

  assign wake_o = wake_q;

  AST_ABORT_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_i || uv_i) |=> (state_q == ST_IDLE)); // R8
  AST_NORMAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_i |=> !wake_q); // R7
  AST_WAKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_q && stby_i) |=> wake_q); // R11
  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (tcnt_q <= TO_LIM)); // R5
  AST_WAKE_FROM_DOM2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_q) |-> (($past(state_q) == ST_DOM2) && $past(filt_i))); // R3

endmodule

// File: rtl/wkp_wake_detector.sv
module wkp_wake_detector #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FLT_CYC     = 4,
  parameter int unsigned DOM_CYC     = 8,
  parameter int unsigned REC_CYC     = 8,
  parameter int unsigned TO_CYC      = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_dom_i,
  input  logic stby_i,
  input  logic vio_uv_i,
  output logic wake_o,
  output logic rxd_o
);

  logic bus_sync;
  logic bus_filt;
  logic wake;

  wkp_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bus_dom_i),
    .q_o    (bus_sync)
  );

  wkp_glitch_filter #(
    .FLT_CYC (FLT_CYC)
  ) i_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (bus_sync),
    .filt_o (bus_filt)
  );

  wkp_seq_fsm #(
    .DOM_CYC (DOM_CYC),
    .REC_CYC (REC_CYC),
    .TO_CYC  (TO_CYC)
  ) i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .filt_i (bus_filt),
    .stby_i (stby_i),
    .uv_i   (vio_uv_i),
    .wake_o (wake)
  );

  assign wake_o = wake;
  // recessive until woken, then the filtered bus (low = dominant)
  assign rxd_o  = wake ? !bus_filt : 1'b1;

endmodule

// File: tb/test_wkp_wake_detector.sv
module test_wkp_wake_detector;

  localparam int S   = 2;
  localparam int FLT = 4;
  localparam int DOM = 8;
  localparam int REC = 8;
  localparam int TO  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_dom = 1'b0;
  logic stby = 1'b1;
  logic uv = 1'b0;
  logic wake, rxd;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int seg_len [16];
  bit seg_dom [16];

  always #10 clk = ~clk;

  wkp_wake_detector #(
    .SYNC_STAGES (S),
    .FLT_CYC     (FLT),
    .DOM_CYC     (DOM),
    .REC_CYC     (REC),
    .TO_CYC      (TO)
  ) i_wkp_wake_detector (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bus_dom_i (bus_dom),
    .stby_i    (stby),
    .vio_uv_i  (uv),
    .wake_o    (wake),
    .rxd_o     (rxd)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // expected outcome of an alternating segment list (seg 0 recessive, all >= FLT)
  function automatic bit exp_wake(input int n);
    int j = 0;
    int d1, r;
    while (j < n) begin
      if (!seg_dom[j]) begin
        j++;
        continue;
      end
      if (j + 1 >= n) return 1'b0;
      d1 = seg_len[j];
      r  = seg_len[j+1];
      if (d1 < DOM || r < REC || d1 + r >= TO) begin
        j += 2;
        continue;
      end
      if (j + 2 >= n) return 1'b0;
      if (seg_len[j+2] >= DOM && d1 + r + DOM <= TO) return 1'b1;
      j += 3;
    end
    return 1'b0;
  endfunction

  task automatic quiesce();
    stby = 1'b0;
    uv = 1'b0;
    bus_dom = 1'b0;
    cyc(S + FLT + 4);
    stby = 1'b1;
  endtask

  task automatic play(input int n);
    for (int j = 0; j < n; j++) begin
      bus_dom = seg_dom[j];
      cyc(seg_len[j]);
    end
    bus_dom = 1'b0;
    cyc(S + FLT + 3);
  endtask

  task automatic set3(input int d1, input int r, input int d2);
    seg_dom[0] = 0; seg_len[0] = 6;
    seg_dom[1] = 1; seg_len[1] = d1;
    seg_dom[2] = 0; seg_len[2] = r;
    seg_dom[3] = 1; seg_len[3] = d2;
    seg_dom[4] = 0; seg_len[4] = 12;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: finished got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int e;
    bit ex;
    void'($urandom(32'h5EED_0A17));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 wake after reset", wake, 1'b0);
    chk("R1 rxd after reset", rxd, 1'b1);

    // exact rise edge, d1=10 r=10
    quiesce();
    e = S + FLT + 10 + 10 + DOM - 1;
    bus_dom = 1'b1; cyc(10);
    bus_dom = 1'b0; cyc(10);
    bus_dom = 1'b1; cyc(e - 20);
    chk("R3 wake one edge early", wake, 1'b0);
    chk("R9 rxd recessive before wake", rxd, 1'b1);
    cyc(1);
    chk("R3 wake on expected edge", wake, 1'b1);
    chk("R10 rxd dominant after wake", rxd, 1'b0);

    bus_dom = 1'b0; cyc(S + FLT + 1);
    chk("R10 rxd follows recessive", rxd, 1'b1);
    bus_dom = 1'b1; cyc(S + FLT + 1);
    chk("R10 rxd follows dominant", rxd, 1'b0);
    bus_dom = 1'b0; cyc(FLT - 1);
    bus_dom = 1'b1;
    for (int k = 0; k < S + FLT + 2; k++) begin
      chk("R2 short recessive ignored on rxd", rxd, 1'b0);
      cyc(1);
    end
    uv = 1'b1; cyc(3);
    chk("R8 undervoltage keeps wake", wake, 1'b1);
    uv = 1'b0; cyc(2);
    chk("R11 wake sticky in standby", wake, 1'b1);
    stby = 1'b0; cyc(1);
    chk("R7 normal mode clears wake", wake, 1'b0);
    chk("R9 rxd recessive after clear", rxd, 1'b1);

    // short phases
    quiesce(); set3(7, 10, 10); play(5);
    chk("R4 short first dominant", wake, 1'b0);
    quiesce(); set3(10, 7, 10); play(5);
    chk("R4 short recessive", wake, 1'b0);
    quiesce(); set3(10, 10, 7); play(5);
    chk("R4 short final dominant", wake, 1'b0);

    // timeout boundary
    quiesce(); set3(28, 28, 10); play(5);
    chk("R5 pattern exactly at limit", wake, 1'b1);
    quiesce(); set3(30, 30, 10); play(5);
    chk("R5 pattern beyond limit", wake, 1'b0);
    quiesce();
    set3(32, 32, 10);
    seg_dom[4] = 0; seg_len[4] = 10;
    seg_dom[5] = 1; seg_len[5] = 10;
    seg_dom[6] = 0; seg_len[6] = 12;
    play(7);
    chk("R5 edge at expiry restarts", wake, 1'b1);

    // clamped bus
    quiesce();
    bus_dom = 1'b1; cyc(300);
    chk("R6 clamped dominant", wake, 1'b0);
    chk("R9 rxd recessive while clamped", rxd, 1'b1);
    bus_dom = 1'b0; cyc(12);
    chk("R6 after clamp release", wake, 1'b0);

    // abort by normal mode inside the gap
    quiesce();
    bus_dom = 1'b1; cyc(10);
    bus_dom = 1'b0; cyc(5);
    stby = 1'b0; cyc(2);
    stby = 1'b1; cyc(5);
    bus_dom = 1'b1; cyc(10);
    bus_dom = 1'b0; cyc(12);
    chk("R7 normal mode discards pattern", wake, 1'b0);

    // abort by undervoltage inside the gap
    quiesce();
    bus_dom = 1'b1; cyc(10);
    bus_dom = 1'b0; cyc(5);
    uv = 1'b1; cyc(2);
    uv = 1'b0; cyc(5);
    bus_dom = 1'b1; cyc(10);
    bus_dom = 1'b0; cyc(12);
    chk("R8 undervoltage discards pattern", wake, 1'b0);

    // glitch inside the recessive gap does not split it
    quiesce();
    bus_dom = 1'b1; cyc(10);
    bus_dom = 1'b0; cyc(5);
    bus_dom = 1'b1; cyc(FLT - 1);
    bus_dom = 1'b0; cyc(5);
    bus_dom = 1'b1; cyc(10);
    bus_dom = 1'b0; cyc(12);
    chk("R2 glitch in gap ignored", wake, 1'b1);

    // train of short pulses
    quiesce();
    for (int k = 0; k < 30; k++) begin
      bus_dom = 1'b1; cyc(FLT - 1);
      bus_dom = 1'b0; cyc(FLT - 1);
    end
    cyc(10);
    chk("R2 short pulses ignored", wake, 1'b0);

    // random segment lists
    for (int t = 0; t < 200; t++) begin
      int np, n;
      quiesce();
      np = $urandom_range(5, 2);
      seg_dom[0] = 0; seg_len[0] = $urandom_range(12, 4);
      n = 1;
      for (int k = 0; k < np; k++) begin
        seg_dom[n] = 1; seg_len[n] = $urandom_range(40, FLT); n++;
        seg_dom[n] = 0; seg_len[n] = $urandom_range(40, FLT); n++;
      end
      seg_len[n-1] += 12;
      ex = exp_wake(n);
      play(n);
      chk(ex ? "R3 random pattern wakes" : "R4 R5 random pattern rejected", wake, ex);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule